// File: doc/BRIEF.md
# I2C Master STOP Generator with Collision Detection

This block produces the STOP condition at the end of an I2C master transfer and watches both bus lines for another master while doing so. It controls SCL and SDA through open-drain pull-down enables (a high enable pulls the line to 0, a low enable lets it float high) and reads the resolved line levels back. A one-cycle request starts the sequence. A 7-bit reload value sets the length of each timed phase, which is counted by an internal down-counting bit timer.

The sequence walks through these states. IDLE drives nothing; a request moves to SDA_LOW. SDA_LOW pulls both SCL and SDA low for one timer period and moves to SCL_REL once the period has ended and SDA reads low. SCL_REL releases SCL and waits, with the timer paused, until SCL reads high, which lets a slave stretch the clock; it then moves to SCL_HIGH. SCL_HIGH keeps SDA low for one timer period and moves to SDA_REL when the period ends, or back to IDLE with a collision if SCL reads low. SDA_REL releases SDA for one timer period and then samples SDA: high returns to IDLE with a completed STOP, low returns to IDLE with a collision.

A completed STOP gives a one-cycle completion pulse and sets a sticky event flag. A collision sets a sticky collision flag and gives no completion pulse. Each flag stays set until its own clear input is pulsed.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset, `busy`, `scl_oe`, `sda_oe`, `stop_done`, `event_flag` and `bus_coll` are all 0.
- R2: A request accepted in IDLE pulls SDA and SCL low from the next cycle on. SCL stays pulled low until one timer period has passed and SDA reads low; while SDA reads high, SCL stays pulled low.
- R3: After SCL is released, the timer does not run until SCL reads high. Each cycle that a slave holds SCL low adds one cycle to the sequence.
- R4: A timer period lasts N cycles, where N is the reload value, or 1 when the reload is 0. With no stretching and no collision, `busy` is high for 3N+1 cycles.
- R5: If SDA reads high when the SDA_REL period ends, `stop_done` is high for exactly the next cycle and `event_flag` becomes 1.
- R6: If SDA reads low when the SDA_REL period ends, `bus_coll` becomes 1, `stop_done` stays 0 and `event_flag` is unchanged.
- R7: SCL reading low in any cycle of SCL_HIGH is a collision. Both enables drop at once and the block goes to IDLE, so `busy` is high for N+S+P+2 cycles, where S is the number of stretch cycles and P is the index of the cycle in SCL_HIGH, counted from 0. SCL going low after SDA has been released is not a collision.
- R8: `bus_coll` stays 1 until `coll_clr` is pulsed, and `event_flag` stays 1 until `evt_clr` is pulsed. Each clear affects only its own flag.
- R9: A `stop_req` pulse while `busy` is 1 changes neither the timing nor the result, and no second sequence follows.
- R10: `busy` drops by itself when the sequence completes or aborts, and both enables are 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | One-cycle request to start a STOP |
| reload | input | 7 | Bit-timer reload value (0 is taken as 1) |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| coll_clr | input | 1 | Clears the collision flag |
| evt_clr | input | 1 | Clears the event flag |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| busy | output | 1 | STOP sequence in progress |
| stop_done | output | 1 | One-cycle pulse when a STOP completes |
| event_flag | output | 1 | Sticky flag for a completed STOP |
| bus_coll | output | 1 | Sticky bus-collision flag |

## Verification
The bench builds the block with the default reload width of 7 bits. That width lets it use reloads of 0, 1 and 127, so it reaches the shortest phase, the case where 0 is treated as 1, and the longest phase while keeping each sequence under 400 cycles. It models both lines as open-drain wires with an external puller. This lets it stretch SCL for a chosen number of cycles, pull SCL low in a chosen cycle of the SCL-high phase or just after it, hold SDA low, and force SDA to read high.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SDA_LOW  = 3'd1,
        ST_SCL_REL  = 3'd2,
        ST_SCL_HIGH = 3'd3,
        ST_SDA_REL  = 3'd4
    } stop_state_e;

endpackage

// File: rtl/i2c_stop_tmr.sv
module i2c_stop_tmr #(
    parameter int RLD_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [RLD_W-1:0] reload,
    output logic             expired
);
    localparam logic [RLD_W-1:0] ONE  = {{(RLD_W-1){1'b0}}, 1'b1};
    localparam logic [RLD_W-1:0] ZERO = '0;

    logic [RLD_W-1:0] cnt;
    logic [RLD_W-1:0] eff;

    // a zero reload still gives a phase of one tick
    assign eff = (reload == ZERO) ? ONE : reload;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else if (load) begin
            cnt <= eff - ONE;
        end else if (run && (cnt != ZERO)) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = run && (cnt == ZERO);

endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
    import i2c_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic scl_in,
    input  logic sda_in,
    input  logic tmr_exp,
    output logic tmr_load,
    output logic tmr_run,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic fin_ok,
    output logic fin_coll
);
    stop_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        fin_ok   = 1'b0;
        fin_coll = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (stop_req) begin
                    state_nx = ST_SDA_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_SDA_LOW: begin
                if (tmr_exp && !sda_in) state_nx = ST_SCL_REL;
            end
            ST_SCL_REL: begin
                if (scl_in) begin
                    state_nx = ST_SCL_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_SCL_HIGH: begin
                if (!scl_in) begin
                    state_nx = ST_IDLE;
                    fin_coll = 1'b1;
                end else if (tmr_exp) begin
                    state_nx = ST_SDA_REL;
                    tmr_load = 1'b1;
                end
            end
            ST_SDA_REL: begin
                if (tmr_exp) begin
                    state_nx = ST_IDLE;
                    fin_ok   = sda_in;
                    fin_coll = !sda_in;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs by state
    always_comb begin
        scl_oe  = 1'b0;
        sda_oe  = 1'b0;
        tmr_run = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_SDA_LOW: begin
                scl_oe  = 1'b1;
                sda_oe  = 1'b1;
                tmr_run = 1'b1;
            end
            ST_SCL_REL:  sda_oe = 1'b1;
            ST_SCL_HIGH: begin
                sda_oe  = 1'b1;
                tmr_run = 1'b1;
            end
            ST_SDA_REL:  tmr_run = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_stop_flags.sv
module i2c_stop_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fin_ok,
    input  logic fin_coll,
    input  logic coll_clr,
    input  logic evt_clr,
    output logic stop_done,
    output logic event_flag,
    output logic bus_coll
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_done  <= 1'b0;
            event_flag <= 1'b0;
            bus_coll   <= 1'b0;
        end else begin
            stop_done <= fin_ok;
            // a new event wins over a clear in the same cycle
            if (fin_ok)       event_flag <= 1'b1;
            else if (evt_clr) event_flag <= 1'b0;
            if (fin_coll)      bus_coll <= 1'b1;
            else if (coll_clr) bus_coll <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen #(
    parameter int RLD_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [RLD_W-1:0] reload,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             coll_clr,
    input  logic             evt_clr,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             stop_done,
    output logic             event_flag,
    output logic             bus_coll
);
    logic tmr_load, tmr_run, tmr_exp;
    logic fin_ok, fin_coll;

    i2c_stop_tmr #(.RLD_W(RLD_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .reload  (reload),
        .expired (tmr_exp)
    );

    i2c_stop_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .tmr_exp  (tmr_exp),
        .tmr_load (tmr_load),
        .tmr_run  (tmr_run),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .fin_ok   (fin_ok),
        .fin_coll (fin_coll)
    );

    i2c_stop_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_ok     (fin_ok),
        .fin_coll   (fin_coll),
        .coll_clr   (coll_clr),
        .evt_clr    (evt_clr),
        .stop_done  (stop_done),
        .event_flag (event_flag),
        .bus_coll   (bus_coll)
    );

endmodule

// File: rtl/i2c_stop_chk.sv
module i2c_stop_chk #(
    parameter int RLD_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic [RLD_W-1:0] reload,
    input logic             scl_in,
    input logic             sda_in,
    input logic             coll_clr,
    input logic             evt_clr,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic             stop_done,
    input logic             event_flag,
    input logic             bus_coll
);
    // R10: nothing is driven outside a sequence
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R2: SCL is let go only while SDA is held and after SDA read low
    a_r2_scl_after_sda: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(scl_oe)) |-> (sda_oe && !$past(sda_in)));

    // R5: completion follows a busy cycle that saw SDA high
    a_r5_done_after_sda_high: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> (!busy && $past(busy) && $past(sda_in)));

    // R5: the completion pulse lasts one cycle
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> !stop_done);

    // R7: a collision leaves both lines released and the block idle
    a_r7_coll_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (!busy && !scl_oe && !sda_oe));

    // R8: the collision flag holds until cleared
    a_r8_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_coll && !coll_clr) |=> bus_coll);

    // R8: the event flag holds until cleared
    a_r8_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flag && !evt_clr) |=> event_flag);

endmodule

bind i2c_stop_gen i2c_stop_chk #(.RLD_W(RLD_W)) u_chk (.*);

// File: tb/i2c_stop_gen_bench.sv
module i2c_stop_gen_bench;

    typedef struct packed {
        logic [6:0] rld;
        logic [7:0] stretch;
        logic [7:0] pull;    // 255 = never pull SCL
        logic       hold;    // hold SDA low from outside
        logic       done;
        logic       coll;
        logic [9:0] cyc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{7'd3,   8'd0, 8'd255, 1'b0, 1'b1, 1'b0, 10'd10},
        '{7'd0,   8'd0, 8'd255, 1'b0, 1'b1, 1'b0, 10'd4},
        '{7'd1,   8'd0, 8'd255, 1'b0, 1'b1, 1'b0, 10'd4},
        '{7'd5,   8'd4, 8'd255, 1'b0, 1'b1, 1'b0, 10'd20},
        '{7'd4,   8'd0, 8'd255, 1'b1, 1'b0, 1'b1, 10'd13},
        '{7'd4,   8'd2, 8'd1,   1'b0, 1'b0, 1'b1, 10'd9},
        '{7'd6,   8'd0, 8'd0,   1'b0, 1'b0, 1'b1, 10'd8},
        '{7'd6,   8'd0, 8'd5,   1'b0, 1'b0, 1'b1, 10'd13},
        '{7'd3,   8'd0, 8'd3,   1'b0, 1'b1, 1'b0, 10'd10},
        '{7'd127, 8'd0, 8'd255, 1'b0, 1'b1, 1'b0, 10'd382},
        '{7'd2,   8'd3, 8'd255, 1'b1, 1'b0, 1'b1, 10'd10}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic [6:0] reload = '0;
    logic       coll_clr = 1'b0;
    logic       evt_clr = 1'b0;
    logic       ext_scl_low = 1'b0;
    logic       ext_sda_low = 1'b0;
    logic       force_sda_hi = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_oe, sda_oe, busy, stop_done, event_flag, bus_coll;

    int checks = 0;
    int failures = 0;
    int cfg_s = 0;
    int cfg_p = 255;
    int rel = 0;

    always #10 clk = ~clk;

    // open-drain lines
    assign scl_in = !(scl_oe || ext_scl_low);
    assign sda_in = force_sda_hi ? 1'b1 : !(sda_oe || ext_sda_low);

    i2c_stop_gen u_i2c_stop_gen (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
        .scl_in(scl_in), .sda_in(sda_in), .coll_clr(coll_clr), .evt_clr(evt_clr),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .stop_done(stop_done),
        .event_flag(event_flag), .bus_coll(bus_coll)
    );

    // external device on SCL: stretch, then an optional one-cycle pull
    always @(negedge clk) begin
        if (!busy || scl_oe) begin
            rel         <= 0;
            ext_scl_low <= 1'b0;
        end else begin
            ext_scl_low <= ((rel + 1) <= cfg_s) ||
                           ((cfg_p != 255) && ((rel + 1) == cfg_s + 2 + cfg_p));
            rel         <= rel + 1;
        end
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start(input logic [6:0] rld);
        @(negedge clk);
        reload   = rld;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    // counts busy cycles from the current negedge, ends on the first idle negedge
    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags;
        @(negedge clk);
        coll_clr = 1'b1;
        evt_clr  = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        evt_clr  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 drives", {scl_oe, sda_oe}, 0);
        chk("R1 flags", {stop_done, event_flag, bus_coll}, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cfg_s       = VEC[i].stretch;
            cfg_p       = VEC[i].pull;
            ext_sda_low = VEC[i].hold;
            start(VEC[i].rld);
            wait_idle(cyc);
            chk($sformatf("R4/R3/R7 vec%0d cycles", i), cyc, VEC[i].cyc);
            chk($sformatf("R5 vec%0d stop_done", i), stop_done, VEC[i].done);
            chk($sformatf("R5 vec%0d event_flag", i), event_flag, VEC[i].done);
            chk($sformatf("R6/R7 vec%0d bus_coll", i), bus_coll, VEC[i].coll);
            chk($sformatf("R10 vec%0d released", i), {busy, scl_oe, sda_oe}, 0);
            ext_sda_low = 1'b0;
            cfg_p       = 255;
            cfg_s       = 0;
            clear_flags();
        end

        // R2 drive order during SDA_LOW and after
        start(7'd4);
        chk("R2 first cycle drives", {scl_oe, sda_oe}, 3);
        repeat (3) @(negedge clk);
        chk("R2 last SDA_LOW cycle scl held", scl_oe, 1);
        @(negedge clk);
        chk("R2 scl released sda held", {scl_oe, sda_oe}, 1);
        wait_idle(cyc);
        @(negedge clk);
        chk("R5 pulse lasts one cycle", stop_done, 0);
        clear_flags();

        // R2 SCL held while SDA reads high
        force_sda_hi = 1'b1;
        start(7'd2);
        repeat (10) @(negedge clk);
        chk("R2 scl held while sda high", {busy, scl_oe}, 3);
        force_sda_hi = 1'b0;
        wait_idle(cyc);
        chk("R2 completes after sda low", stop_done, 1);
        clear_flags();

        // R9 request while busy
        start(7'd5);
        repeat (2) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_idle(cyc);
        chk("R9 cycles unchanged", cyc + 3, 16);
        chk("R9 done once", stop_done, 1);
        repeat (3) @(negedge clk);
        chk("R9 no second sequence", busy, 0);
        clear_flags();

        // R8 stickiness and separate clears
        ext_sda_low = 1'b1;
        start(7'd2);
        wait_idle(cyc);
        ext_sda_low = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 coll sticky", bus_coll, 1);
        start(7'd2);
        wait_idle(cyc);
        chk("R8 coll kept across good stop", bus_coll, 1);
        chk("R8 event set", event_flag, 1);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        chk("R8 evt_clr clears event", event_flag, 0);
        chk("R8 evt_clr leaves coll", bus_coll, 1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        chk("R8 coll_clr clears coll", bus_coll, 0);

        report();
        $finish;
    end

endmodule